// File: doc/BRIEF.md
# Down-counting timer with repeat modes

This block is a down-counter with a programmable clock divider, a reload value and two repeat counters. Once started, it steps down by one on each divided tick. When it steps below zero it underflows and reloads from its top value. The top value is either a fixed constant or the first compare register. Each underflow can decrement the repeat counters, depending on the selected repeat mode. The repeat mode therefore decides whether the timer keeps running, stops, or takes a fresh repeat count from the second repeat register.

Software drives the block through a small word-addressed register port. The write port has address and data. The read port is a separate combinational read address. Start, stop and clear are write-only command bits. Five hardware events set sticky flags, and software clears a flag by writing one to it. A mask register selects which flags drive the single interrupt output. An optional buffered-top setting copies the second compare register into the first each time repeat counter 0 runs out. This lets the next period be prepared while the current one is running.

Top module: `lp_downtimer`

## Requirements
- R1: After synchronous reset, every readable register reads zero, the running bit is 0 and `irq` is low.
- R2: While running, each tick moves the count down by one. A tick at count 0 is an underflow and loads the top value instead. The top value is FIXED_TOP when control bit 2 (top select) is 0, and the COMP0 register when it is 1.
- R3: Control bits 7:4 hold the divider code N. A tick occurs every 2^N clock cycles, and the first tick comes 2^N cycles after the start command is accepted. Codes from 0 to 8 are supported.
- R4: Repeat mode 0 (free, control bits 1:0) keeps counting until a stop command and never changes REP0.
- R5: In mode 1 (one-shot), each underflow decrements REP0. The underflow seen with REP0 = 1, or with REP0 = 0, stops the timer. The run therefore lasts (CNT+1) + (REP0-1)·(top+1) ticks.
- R6: In mode 2 (buffered), when REP0 runs out, REP1 is copied into REP0 if REP1 was written since the last copy, and counting continues. Otherwise the timer stops.
- R7: In mode 3 (double), each underflow decrements both REP0 and REP1, saturating at zero. The timer stops on the underflow after which both are zero.
- R8: With control bit 3 (buffered top) set, COMP0 takes the value of COMP1 on each underflow where REP0 runs out (modes 1 to 3). That same reload still uses the old COMP0.
- R9: The flag register bits are: 0 = the count entered COMP0, 1 = the count entered COMP1, 2 = underflow, 3 = REP0 ran out, 4 = REP1 ran out. The flags are sticky, and writing 1 to a bit clears it.
- R10: `irq` is high exactly when some flag bit and the same bit of the enable register are both set.
- R11: Command bits are 0 = start, 1 = stop and 2 = clear. Clear zeroes the count and restarts the divider. Stop overrides start in the same write, and start together with clear both take effect.
- R12: The word addresses are 0 control, 1 command, 2 count, 3 COMP0, 4 COMP1, 5 REP0, 6 REP1, 7 flags, 8 enable, 9 status (bit 0 = running). A read of the command word returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 4 | Word address of the read |
| rd_data | output | CNT_W | Read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the timer with an 8-bit counter, 4-bit repeat counters and a fixed top of 20. It sweeps divider codes 0 to 3, top values 2 to 5, repeat counts 1 to 3 and several start counts in one-shot mode. For each case it compares the running time in cycles and the end state with the closed-form tick count. With the small fixed top, a fixed-top run fits in a few dozen cycles. The small widths also keep the buffered, double, buffered-top, flag and command-priority scenarios short enough to check cycle by cycle.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    typedef enum logic [1:0] {
        RM_FREE     = 2'd0,
        RM_ONESHOT  = 2'd1,
        RM_BUFFERED = 2'd2,
        RM_DOUBLE   = 2'd3
    } rep_mode_e;

    typedef struct packed {
        logic [3:0] presc;
        logic       buf_top;
        logic       top_sel;
        rep_mode_e  mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
    localparam logic [ADDR_W-1:0] A_CMD   = 4'd1;
    localparam logic [ADDR_W-1:0] A_CNT   = 4'd2;
    localparam logic [ADDR_W-1:0] A_CMP0  = 4'd3;
    localparam logic [ADDR_W-1:0] A_CMP1  = 4'd4;
    localparam logic [ADDR_W-1:0] A_REP0  = 4'd5;
    localparam logic [ADDR_W-1:0] A_REP1  = 4'd6;
    localparam logic [ADDR_W-1:0] A_FLAGS = 4'd7;
    localparam logic [ADDR_W-1:0] A_IEN   = 4'd8;
    localparam logic [ADDR_W-1:0] A_STAT  = 4'd9;

    localparam int CMD_START = 0;
    localparam int CMD_STOP  = 1;
    localparam int CMD_CLEAR = 2;

    // bit 0 is cmp0, bit 4 is rep1_z
    typedef struct packed {
        logic rep1_z;
        logic rep0_z;
        logic uf;
        logic cmp1;
        logic cmp0;
    } evt_t;

    localparam int EVT_W = $bits(evt_t);

endpackage

// File: rtl/lpt_prescaler.sv
module lpt_prescaler #(
    parameter int DIV_W  = 8,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    // low N bits of the mask set: tick when they are all ones
    always_comb begin
        for (int i = 0; i < DIV_W; i++) begin
            mask[i] = (i < int'(code));
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run || restart) div_q <= '0;
        else                        div_q <= div_q + 1'b1;
    end

    assign tick = run && ((div_q & mask) == mask);
endmodule

// File: rtl/lpt_repeat.sv
module lpt_repeat
    import lpt_pkg::*;
#(
    parameter int REP_W = 8
) (
    input  rep_mode_e        mode,
    input  logic             uf,
    input  logic [REP_W-1:0] rep0,
    input  logic [REP_W-1:0] rep1,
    input  logic             rep1_vld,
    output logic [REP_W-1:0] rep0_nxt,
    output logic [REP_W-1:0] rep1_nxt,
    output logic             consume,
    output logic             halt,
    output logic             rep0_ev,
    output logic             rep1_ev
);
    logic             r0_last, r1_last;
    logic [REP_W-1:0] r0_dec, r1_dec;

    assign r0_last = (rep0 <= REP_W'(1));
    assign r1_last = (rep1 <= REP_W'(1));
    assign r0_dec  = (rep0 == '0) ? '0 : rep0 - 1'b1;
    assign r1_dec  = (rep1 == '0) ? '0 : rep1 - 1'b1;

    always_comb begin
        rep0_nxt = rep0;
        rep1_nxt = rep1;
        consume  = 1'b0;
        halt     = 1'b0;
        rep0_ev  = 1'b0;
        rep1_ev  = 1'b0;
        if (uf) begin
            case (mode)
                RM_ONESHOT: begin
                    rep0_ev  = (rep0 == REP_W'(1));
                    rep0_nxt = r0_dec;
                    halt     = r0_last;
                end
                RM_BUFFERED: begin
                    rep0_ev = (rep0 == REP_W'(1));
                    if (!r0_last) begin
                        rep0_nxt = r0_dec;
                    end else if (rep1_vld) begin
                        rep0_nxt = rep1;
                        consume  = 1'b1;
                    end else begin
                        rep0_nxt = '0;
                        halt     = 1'b1;
                    end
                end
                RM_DOUBLE: begin
                    rep0_ev  = (rep0 == REP_W'(1));
                    rep1_ev  = (rep1 == REP_W'(1));
                    rep0_nxt = r0_dec;
                    rep1_nxt = r1_dec;
                    halt     = r0_last && r1_last;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/lpt_irq.sv
module lpt_irq #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic         clr_we,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] ien,
    output logic [N-1:0] flags,
    output logic         irq
);
    for (genvar g = 0; g < N; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst) flags[g] <= 1'b0;
            else     flags[g] <= set[g] | (flags[g] & ~(clr_we & clr_bits[g]));
        end
    end

    assign irq = |(flags & ien);
endmodule

// File: rtl/lp_downtimer.sv
module lp_downtimer
    import lpt_pkg::*;
#(
    parameter int               CNT_W     = 24,
    parameter int               REP_W     = 8,
    parameter int               DIV_W     = 8,
    parameter logic [CNT_W-1:0] FIXED_TOP = CNT_W'('hFFFF)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    ctrl_t             ctrl_q;
    logic [CNT_W-1:0]  cnt_q, cmp0_q, cmp1_q;
    logic [REP_W-1:0]  rep0_q, rep1_q;
    logic              rep1_vld, running;
    logic [EVT_W-1:0]  ien_q, flags_w;

    logic hit_ctrl, hit_cmd, hit_cnt, hit_cmp0, hit_cmp1;
    logic hit_rep0, hit_rep1, hit_flags, hit_ien;
    logic cmd_start, cmd_stop, cmd_clear;
    logic tick, adv, uf;
    logic [CNT_W-1:0]  top_val, cnt_step;
    logic [REP_W-1:0]  r0_nxt, r1_nxt;
    logic consume, halt, r0_ev, r1_ev;
    evt_t ev;

    assign hit_ctrl  = wr_en && (wr_addr == A_CTRL);
    assign hit_cmd   = wr_en && (wr_addr == A_CMD);
    assign hit_cnt   = wr_en && (wr_addr == A_CNT);
    assign hit_cmp0  = wr_en && (wr_addr == A_CMP0);
    assign hit_cmp1  = wr_en && (wr_addr == A_CMP1);
    assign hit_rep0  = wr_en && (wr_addr == A_REP0);
    assign hit_rep1  = wr_en && (wr_addr == A_REP1);
    assign hit_flags = wr_en && (wr_addr == A_FLAGS);
    assign hit_ien   = wr_en && (wr_addr == A_IEN);

    assign cmd_start = hit_cmd && wr_data[CMD_START];
    assign cmd_stop  = hit_cmd && wr_data[CMD_STOP];
    assign cmd_clear = hit_cmd && wr_data[CMD_CLEAR];

    lpt_prescaler #(.DIV_W(DIV_W), .CODE_W(4)) u_presc (
        .clk(clk), .rst(rst), .run(running), .restart(cmd_clear),
        .code(ctrl_q.presc), .tick(tick)
    );

    // software writes to the count take the cycle over from the tick
    assign adv      = tick && !cmd_clear && !hit_cnt;
    assign uf       = adv && (cnt_q == '0);
    assign top_val  = ctrl_q.top_sel ? cmp0_q : FIXED_TOP;
    assign cnt_step = (cnt_q == '0) ? top_val : cnt_q - 1'b1;

    lpt_repeat #(.REP_W(REP_W)) u_rep (
        .mode(ctrl_q.mode), .uf(uf), .rep0(rep0_q), .rep1(rep1_q),
        .rep1_vld(rep1_vld), .rep0_nxt(r0_nxt), .rep1_nxt(r1_nxt),
        .consume(consume), .halt(halt), .rep0_ev(r0_ev), .rep1_ev(r1_ev)
    );

    always_comb begin
        ev.cmp0   = adv && (cnt_step == cmp0_q);
        ev.cmp1   = adv && (cnt_step == cmp1_q);
        ev.uf     = uf;
        ev.rep0_z = r0_ev;
        ev.rep1_z = r1_ev;
    end

    lpt_irq #(.N(EVT_W)) u_irq (
        .clk(clk), .rst(rst), .set(ev), .clr_we(hit_flags),
        .clr_bits(wr_data[EVT_W-1:0]), .ien(ien_q), .flags(flags_w), .irq(irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            cnt_q    <= '0;
            cmp0_q   <= '0;
            cmp1_q   <= '0;
            rep0_q   <= '0;
            rep1_q   <= '0;
            rep1_vld <= 1'b0;
            ien_q    <= '0;
            running  <= 1'b0;
        end else begin
            if (hit_ctrl) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
            if (hit_cnt)        cnt_q <= wr_data;
            else if (cmd_clear) cnt_q <= '0;
            else if (adv)       cnt_q <= cnt_step;
            if (hit_cmp0) cmp0_q <= wr_data;
            else if (ctrl_q.buf_top && r0_ev) cmp0_q <= cmp1_q;
            if (hit_cmp1) cmp1_q <= wr_data;
            if (hit_rep0) rep0_q <= wr_data[REP_W-1:0];
            else if (adv) rep0_q <= r0_nxt;
            if (hit_rep1) begin
                rep1_q   <= wr_data[REP_W-1:0];
                rep1_vld <= 1'b1;
            end else begin
                if (adv)     rep1_q   <= r1_nxt;
                if (consume) rep1_vld <= 1'b0;
            end
            if (hit_ien) ien_q <= wr_data[EVT_W-1:0];
            if (cmd_stop)       running <= 1'b0;
            else if (cmd_start) running <= 1'b1;
            else if (halt)      running <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_CTRL:  rd_data[CTRL_W-1:0] = ctrl_q;
            A_CNT:   rd_data = cnt_q;
            A_CMP0:  rd_data = cmp0_q;
            A_CMP1:  rd_data = cmp1_q;
            A_REP0:  rd_data[REP_W-1:0] = rep0_q;
            A_REP1:  rd_data[REP_W-1:0] = rep1_q;
            A_FLAGS: rd_data[EVT_W-1:0] = flags_w;
            A_IEN:   rd_data[EVT_W-1:0] = ien_q;
            A_STAT:  rd_data[0] = running;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/lpt_checker.sv
module lpt_checker
    import lpt_pkg::*;
#(
    parameter int CNT_W = 24,
    parameter int REP_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic              tick,
    input logic              running,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  top_val,
    input logic [EVT_W-1:0]  flags,
    input rep_mode_e         mode,
    input logic [REP_W-1:0]  rep0
);
    logic cmd_w, sw_cnt;
    assign cmd_w  = wr_en && (wr_addr == A_CMD);
    assign sw_cnt = (wr_en && (wr_addr == A_CNT)) || (cmd_w && wr_data[CMD_CLEAR]);

    // R11
    stop_wins_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_w && wr_data[CMD_STOP] |=> !running);

    // R11
    clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_w && wr_data[CMD_CLEAR] |=> cnt == '0);

    // R2
    step_down_chk: assert property (@(posedge clk) disable iff (rst)
        tick && !sw_cnt && cnt != '0 |=> cnt == $past(cnt) - 1'b1);

    // R2
    reload_top_chk: assert property (@(posedge clk) disable iff (rst)
        tick && !sw_cnt && cnt == '0 |=> cnt == $past(top_val));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !running && !sw_cnt |=> $stable(cnt));

    // R3
    tick_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
        tick |-> running);

    // R9
    sticky_flags_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && wr_addr == A_FLAGS) |=> (flags & $past(flags)) == $past(flags));

    // R5
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
        tick && !sw_cnt && !cmd_w && cnt == '0 && mode == RM_ONESHOT
        && rep0 <= REP_W'(1) |=> !running);
endmodule

bind lp_downtimer lpt_checker #(.CNT_W(CNT_W), .REP_W(REP_W)) chk_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .tick(tick), .running(running), .cnt(cnt_q), .top_val(top_val),
    .flags(flags_w), .mode(ctrl_q.mode), .rep0(rep0_q)
);

// File: tb/lp_downtimer_tb.sv
module lp_downtimer_tb_top;
    import lpt_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;
    localparam int RW = 4;
    localparam int FTOP = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [3:0]    wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic [3:0]    rd_addr = '0;
    logic [CW-1:0] rd_data;
    logic          irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    lp_downtimer #(.CNT_W(CW), .REP_W(RW), .DIV_W(8), .FIXED_TOP(CW'(FTOP))) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = CW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        rd_addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic expect_reg(input logic [3:0] a, input int exp, input string tag);
        int v;
        rd(a, v);
        chk(v == exp, tag, v, exp);
    endtask

    // ctrl word: presc[7:4] buf_top[3] top_sel[2] mode[1:0]
    task automatic setup(input int mode, input int n, input int tsel, input int btop,
                         input int t, input int c, input int r0);
        wr(A_FLAGS, 31);
        wr(A_CTRL, (n << 4) | (btop << 3) | (tsel << 2) | mode);
        wr(A_CMP0, t);
        wr(A_CNT, c);
        wr(A_REP0, r0);
    endtask

    task automatic run_count(output int n);
        int v;
        wr(A_CMD, 1);
        n = 0;
        rd(A_STAT, v);
        while (v[0] && n < 5000) begin
            n++;
            @(negedge clk);
            rd(A_STAT, v);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n, v, exp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 10; a++) expect_reg(4'(a), 0, "R1 reset register");
        chk(irq == 1'b0, "R1 irq after reset", int'(irq), 0);

        // R3 R5 sweep of divider, top, repeat, start count
        for (int p = 0; p < 4; p++)
            for (int t = 2; t <= 5; t++)
                for (int r = 1; r <= 3; r++) begin
                    int c;
                    c = (t + r) % 4;
                    setup(1, p, 1, 0, t, c, r);
                    run_count(n);
                    exp = ((c + 1) + (r - 1) * (t + 1)) << p;
                    chk(n == exp, "R3 R5 one-shot run length", n, exp);
                    expect_reg(A_CNT, t, "R2 R5 count reloaded at stop");
                    expect_reg(A_REP0, 0, "R5 REP0 exhausted");
                end

        // R2 fixed top
        setup(1, 0, 0, 0, 3, 0, 2);
        run_count(n);
        chk(n == 1 + FTOP + 1, "R2 fixed top run length", n, FTOP + 2);
        expect_reg(A_CNT, FTOP, "R2 fixed top reload");

        // R4 free running, R2 step sequence
        setup(0, 0, 1, 0, 5, 0, 3);
        wr(A_CMD, 1);
        for (int k = 0; k < 13; k++) begin
            exp = (k == 0) ? 0 : 5 - ((k - 1) % 6);
            rd(A_CNT, v);
            chk(v == exp, "R2 R4 free-run count", v, exp);
            @(negedge clk);
        end
        expect_reg(A_STAT, 1, "R4 free mode still running");
        expect_reg(A_REP0, 3, "R4 free mode leaves REP0");
        wr(A_CMD, 2);
        expect_reg(A_STAT, 0, "R4 stop command");
        rd(A_CNT, exp);
        repeat (5) @(negedge clk);
        expect_reg(A_CNT, exp, "R4 count frozen after stop");

        // R6 buffered reload then stop
        setup(2, 0, 1, 0, 3, 0, 2);
        wr(A_REP1, 3);
        run_count(n);
        chk(n == 1 + 4 + 12, "R6 buffered run length", n, 17);
        expect_reg(A_REP0, 0, "R6 REP0 after buffered run");
        setup(2, 0, 1, 0, 3, 0, 1);
        run_count(n);
        chk(n == 1, "R6 no fresh REP1 stops", n, 1);

        // R7 double, R9 flags
        wr(A_CMP1, 200);
        setup(3, 1, 1, 0, 3, 0, 2);
        wr(A_REP1, 4);
        run_count(n);
        chk(n == (1 + 3 * 4) * 2, "R7 double run length", n, 26);
        expect_reg(A_REP0, 0, "R7 REP0 zero");
        expect_reg(A_REP1, 0, "R7 REP1 zero");
        expect_reg(A_FLAGS, 5'h1D, "R9 double-mode flags");

        // R8 buffered top, one-shot
        wr(A_CMP1, 6);
        setup(1, 0, 1, 1, 3, 0, 2);
        run_count(n);
        chk(n == 5, "R8 one-shot buffered top length", n, 5);
        expect_reg(A_CNT, 3, "R8 last reload uses old COMP0");
        expect_reg(A_CMP0, 6, "R8 COMP0 takes COMP1");

        // R8 buffered top, buffered mode
        wr(A_CMP1, 5);
        setup(2, 0, 1, 1, 2, 0, 1);
        wr(A_REP1, 1);
        run_count(n);
        chk(n == 4, "R8 R6 buffered top length", n, 4);
        expect_reg(A_CNT, 5, "R8 second reload uses new COMP0");

        // R9 R10 flags and interrupt mask
        wr(A_CMP1, 2);
        setup(1, 0, 1, 0, 4, 0, 2);
        run_count(n);
        chk(n == 6, "R5 flag run length", n, 6);
        expect_reg(A_FLAGS, 5'h0F, "R9 one-shot flags");
        wr(A_IEN, 5'h10);
        chk(irq == 1'b0, "R10 masked irq", int'(irq), 0);
        wr(A_IEN, 5'h08);
        chk(irq == 1'b1, "R10 enabled irq", int'(irq), 1);
        wr(A_FLAGS, 5'h08);
        expect_reg(A_FLAGS, 5'h07, "R9 write-one clear");
        chk(irq == 1'b0, "R10 irq after clear", int'(irq), 0);
        wr(A_IEN, 0);

        // R11 command priority, R12 command reads zero
        setup(0, 0, 1, 0, 5, 9, 0);
        wr(A_CMD, 3);
        expect_reg(A_STAT, 0, "R11 stop beats start");
        expect_reg(A_CNT, 9, "R11 count kept while stopped");
        wr(A_CMD, 5);
        expect_reg(A_STAT, 1, "R11 start with clear runs");
        expect_reg(A_CNT, 0, "R11 clear zeroes count");
        expect_reg(A_CMD, 0, "R12 command reads zero");
        wr(A_CMD, 3);
        expect_reg(A_STAT, 0, "R11 stop beats start while running");
        expect_reg(A_CTRL, 8'h04, "R12 control readback");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule